// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a synchronous host and an asynchronous 16-bit EDO DRAM whose address pins are shared between a 12-bit row and a 10-bit column. The host hands over one request at a time on a valid/ready port. Each request carries a 22-bit word address (row in the upper 12 bits, column in the lower 10), a write flag, two byte enables and write data. The block turns it into the strobe sequence the memory expects. Read data comes back with a one-cycle valid pulse.

After an access the row stays open: RAS is held low and the block waits in idle with both CAS strobes high. A later request to the same row goes straight to a column cycle (page mode). A request to another row first raises RAS for a precharge window. Every delay is a clock-cycle count given as a parameter, so one netlist covers either speed grade at any clock rate. The delays are row-to-column, column access, row access, CAS precharge and RAS precharge. Each byte lane has its own CAS strobe. A disabled byte therefore keeps its strobe high and is neither written nor returned.

Top module: `edo_seq`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, the outputs are as follows: RAS, both CAS strobes, WE and OE are high, the data-bus enable is low, rsp_valid is low and req_ready is high.
- R2: A request that finds no row open drives RAS low for T_RCD cycles with both CAS strobes high before the column cycle. During that window dram_addr equals req_addr[21:10].
- R3: In every column cycle, dram_addr equals req_addr[9:0] zero-extended to 12 bits. dram_lcas_n is low exactly when req_be[0] was set, and dram_ucas_n is low exactly when req_be[1] was set. Bit 0 is the low byte (data bits 7:0) and bit 1 is the high byte (data bits 15:8).
- R4: A read column cycle has WE high, OE low and the data-bus enable low. A write column cycle has WE low, OE high, the data-bus enable high and dram_dq_out equal to req_wdata. Outside column cycles WE and OE are high and the bus enable is low.
- R5: A write column phase lasts T_CAC cycles. A read column phase lasts max(T_CAC, T_RAC − k) cycles, where k is the number of cycles RAS has already been low when the phase starts.
- R6: One cycle after the last read column cycle, rsp_valid is high for exactly one cycle. Each byte lane of rsp_rdata then holds dram_dq_in as it was at the end of that column cycle if the lane was enabled, and zero if it was not. Writes produce no response.
- R7: Each column phase is followed by T_CP cycles with both CAS strobes high and RAS low. The block then idles with RAS still low (the row stays open).
- R8: A request to the open row starts its column phase in the cycle after acceptance, without raising RAS.
- R9: A request to a different row than the open one raises RAS for T_RP cycles, then follows the R2 sequence.
- R10: req_ready is high only in idle. A request is taken only in a cycle with req_valid and req_ready both high, and no strobe moves while req_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 22 | Word address, row in [21:10], column in [9:0] |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data to drive on the memory bus |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data read from the memory bus |

## Verification
The bench runs a behavioural memory and an expected-pin timeline and compares every strobe on every cycle. The first request is a word write into a closed bank, which separates the row-open path from the page path. It is followed by an immediate read to the same row, where the row-access count rather than the column count limits the phase; this separates the two terms of R5. Single-byte writes and reads, including a request with no byte enabled, show whether the strobes act per lane and whether disabled lanes read as zero even when the memory drives garbage on them. A row change after a long idle gap, followed by back-to-back hits, exercises the precharge path and the case where the column count alone sets the phase length.

// File: rtl/edo_seq_pkg.sv
// Shared types for the EDO DRAM sequencer.
// Assumes nothing beyond a SystemVerilog-2017 tool.
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting; row may be open
        ST_RCD,    // row strobe low, row address out
        ST_CAS,    // column strobe(s) low
        ST_CPRE,   // column precharge, row held
        ST_RPRE    // row precharge before a new row
    } seq_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_timer.sv
// Down-counter for phase lengths. Loading value N gives N+1 cycles
// until zero is seen (zero is high in the last cycle of the phase).
// Assumes load is pulsed on the edge that enters a new phase.
module edo_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // counts down to zero and holds there until reloaded
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/edo_row_track.sv
// Remembers which row is open and compares it with an incoming row.
// Assumes open_set and close are never high in the same cycle.
module edo_row_track #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] row_set,
    input  logic [ROW_W-1:0] row_cmp,
    output logic             is_open,
    output logic             hit
);
    logic [ROW_W-1:0] row_q;

    // tracks the open flag and the row captured when it opened
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            row_q   <= '0;
        end else if (close) begin
            is_open <= 1'b0;
        end else if (open_set) begin
            is_open <= 1'b1;
            row_q   <= row_set;
        end
    end

    assign hit = is_open && (row_q == row_cmp);
endmodule

// File: rtl/edo_rd_lanes.sv
// Masks read data per byte lane: disabled lanes return zero.
// Assumes DATA_W splits into LANES equal lanes.
module edo_rd_lanes #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LW = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LW +: LW] = be[g] ? din[g*LW +: LW] : '0;
    end
endmodule

// File: rtl/edo_seq.sv
// EDO DRAM access sequencer. Turns one host request at a time into
// RAS/CAS/WE/OE sequences, keeps the row open for page-mode hits and
// precharges before changing rows. All delays are cycle counts (>= 1).
// Assumes COL_W <= ROW_W and that refresh is handled elsewhere.
module edo_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 2,
    parameter int T_CAC  = 3,
    parameter int T_RAC  = 12,
    parameter int T_RP   = 4,
    parameter int T_CP   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic                     req_write,
    input  logic [1:0]               req_be,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     dram_ras_n,
    output logic                     dram_lcas_n,
    output logic                     dram_ucas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [ROW_W-1:0]         dram_addr,
    output logic [DATA_W-1:0]        dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [DATA_W-1:0]        dram_dq_in
);
    localparam int T_MAX  = max_of(max_of(T_RCD, T_CAC), max_of(T_RP, T_CP));
    localparam int CNT_W  = $clog2(T_MAX + 1);
    localparam int RAGE_W = $clog2(T_RAC + 1);
    localparam logic [RAGE_W-1:0] RAGE_SAT = RAGE_W'(T_RAC - 1);

    seq_state_t        state, state_n;
    logic [ROW_W-1:0]  q_row;
    logic [COL_W-1:0]  q_col;
    logic              q_wr;
    logic [1:0]        q_be;
    logic [DATA_W-1:0] q_wd;
    logic [RAGE_W-1:0] rage;
    logic              tmr_load, tmr_zero, row_open, row_hit, cas_done, accept;
    logic [CNT_W-1:0]  tmr_val;
    logic [DATA_W-1:0] rd_masked;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cas_done  = tmr_zero && (q_wr || (rage >= RAGE_SAT));

    edo_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    edo_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .open_set(state == ST_RCD), .close(state_n == ST_RPRE),
        .row_set(q_row), .row_cmp(req_addr[ROW_W+COL_W-1:COL_W]),
        .is_open(row_open), .hit(row_hit)
    );

    edo_rd_lanes #(.DATA_W(DATA_W), .LANES(2)) u_lanes (
        .be(q_be), .din(dram_dq_in), .dout(rd_masked)
    );

    // next-state selection per phase
    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE: if (accept) begin
                if (row_hit)       state_n = ST_CAS;
                else if (row_open) state_n = ST_RPRE;
                else               state_n = ST_RCD;
            end
            ST_RPRE: if (tmr_zero) state_n = ST_RCD;
            ST_RCD:  if (tmr_zero) state_n = ST_CAS;
            ST_CAS:  if (cas_done) state_n = ST_CPRE;
            ST_CPRE: if (tmr_zero) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // phase timer reload on every phase change
    always_comb begin
        tmr_load = (state_n != state);
        case (state_n)
            ST_RCD:  tmr_val = CNT_W'(T_RCD - 1);
            ST_CAS:  tmr_val = CNT_W'(T_CAC - 1);
            ST_CPRE: tmr_val = CNT_W'(T_CP - 1);
            ST_RPRE: tmr_val = CNT_W'(T_RP - 1);
            default: tmr_val = '0;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            q_row <= '0;
            q_col <= '0;
            q_wr  <= 1'b0;
            q_be  <= '0;
            q_wd  <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                q_row <= req_addr[ROW_W+COL_W-1:COL_W];
                q_col <= req_addr[COL_W-1:0];
                q_wr  <= req_write;
                q_be  <= req_be;
                q_wd  <= req_wdata;
            end
        end
    end

    // cycles since RAS fell, saturating at T_RAC-1
    always_ff @(posedge clk) begin
        if (!rst_n || dram_ras_n) rage <= '0;
        else if (rage < RAGE_SAT) rage <= rage + 1'b1;
    end

    // read response capture at the end of a read column phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_CAS) && cas_done && !q_wr;
            if ((state == ST_CAS) && cas_done && !q_wr) rsp_rdata <= rd_masked;
        end
    end

    // memory pins decoded from the phase
    always_comb begin
        dram_ras_n  = !((state == ST_RCD) || (state == ST_CAS) ||
                        (state == ST_CPRE) || ((state == ST_IDLE) && row_open));
        dram_lcas_n = !((state == ST_CAS) && q_be[0]);
        dram_ucas_n = !((state == ST_CAS) && q_be[1]);
        dram_we_n   = !((state == ST_CAS) && q_wr);
        dram_oe_n   = !((state == ST_CAS) && !q_wr);
        dram_dq_oe  = (state == ST_CAS) && q_wr;
        dram_dq_out = q_wd;
        dram_addr   = ((state == ST_CAS) || (state == ST_CPRE)) ? ROW_W'(q_col) : q_row;
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_lcas_n || !dram_ucas_n) |-> !dram_ras_n);                 // R7
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_we_n && !dram_oe_n));                                    // R4
    AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && !dram_ras_n));                     // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                       // R6
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n)); // R10
    AST_PRECHARGE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> !req_ready);                               // R9
endmodule

// File: tb/edo_seq_tb.sv
module edo_seq_tb_top;
    localparam int T_RCD = 2, T_CAC = 3, T_RAC = 12, T_RP = 4, T_CP = 2;
    localparam logic [2:0] PH_IDLE = 0, PH_PRE = 1, PH_RCD = 2, PH_CAS = 3, PH_CPRE = 4;

    typedef struct packed {
        logic [2:0]  ph;
        logic        ras, lcas, ucas, we, oe, dqoe, rdy, rsp;
        logic        chk_a;
        logic [11:0] a;
        logic        chk_d;
        logic [15:0] d;
        logic [15:0] rd;
    } exp_t;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0, dram_dq_in = '0;
    logic        req_ready, rsp_valid, dram_ras_n, dram_lcas_n, dram_ucas_n;
    logic        dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] rsp_rdata, dram_dq_out;
    logic [11:0] dram_addr;

    int n_chk = 0, n_fail = 0, cyc = 0, ras_fall = 0;
    bit cur_idle = 0, model_open = 0, finished = 0;
    int model_row = 0;
    exp_t q[$];
    logic [15:0] ref_mem [int];
    logic [15:0] dram_mem [int];

    always #2.5 clk = ~clk;   // 200 MHz

    edo_seq #(.T_RCD(T_RCD), .T_CAC(T_CAC), .T_RAC(T_RAC), .T_RP(T_RP), .T_CP(T_CP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
        .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    function automatic logic [15:0] dflt(input int key);
        return key[15:0] * 16'd37 ^ 16'h5A3C;
    endfunction

    function automatic exp_t mk(input logic [2:0] ph);
        exp_t e = '0;
        e.ph = ph; e.ras = 0; e.lcas = 1; e.ucas = 1; e.we = 1; e.oe = 1;
        return e;
    endfunction

    // behavioural memory on the DRAM pins, evaluated mid-cycle
    logic prev_ras = 1;
    logic [11:0] dm_row = '0;
    int dm_key;
    logic [15:0] dm_word;
    always @(negedge clk) begin
        if (prev_ras && !dram_ras_n) dm_row = dram_addr;
        prev_ras = dram_ras_n;
        dm_key  = {dm_row, dram_addr[9:0]};
        dm_word = dram_mem.exists(dm_key) ? dram_mem[dm_key] : dflt(dm_key);
        if (!dram_ras_n && !dram_we_n && dram_dq_oe) begin
            if (!dram_lcas_n) dm_word[7:0]  = dram_dq_out[7:0];
            if (!dram_ucas_n) dm_word[15:8] = dram_dq_out[15:8];
            dram_mem[dm_key] = dm_word;
        end
        dram_dq_in[7:0]  = (!dram_ras_n && !dram_oe_n && !dram_lcas_n) ? dm_word[7:0]  : 8'hEE;
        dram_dq_in[15:8] = (!dram_ras_n && !dram_oe_n && !dram_ucas_n) ? dm_word[15:8] : 8'hEE;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the expected pin timeline
    always @(posedge clk) begin
        exp_t e;
        string rr;
        #1;
        if (!rst_n) begin
            chk("R1", "ras_n", dram_ras_n, 1);   chk("R1", "lcas_n", dram_lcas_n, 1);
            chk("R1", "ucas_n", dram_ucas_n, 1); chk("R1", "we_n", dram_we_n, 1);
            chk("R1", "oe_n", dram_oe_n, 1);     chk("R1", "dq_oe", dram_dq_oe, 0);
            chk("R1", "rsp_valid", rsp_valid, 0); chk("R1", "req_ready", req_ready, 1);
        end else begin
            cyc++;
            if (q.size() != 0) begin
                e = q.pop_front();
                cur_idle = 0;
            end else begin
                e = mk(PH_IDLE);
                e.ras = !model_open;
                e.rdy = 1;
                cur_idle = 1;
            end
            rr = (e.ph == PH_PRE) ? "R9" : (e.ph == PH_RCD) ? "R2" :
                 (e.ph == PH_CAS) ? "R8" : (model_open ? "R7" : "R1");
            chk(rr, "ras_n", dram_ras_n, e.ras);
            chk((e.ph == PH_CAS) ? "R3/R5" : "R7", "lcas_n", dram_lcas_n, e.lcas);
            chk((e.ph == PH_CAS) ? "R3/R5" : "R7", "ucas_n", dram_ucas_n, e.ucas);
            chk("R4", "we_n", dram_we_n, e.we);
            chk("R4", "oe_n", dram_oe_n, e.oe);
            chk("R4", "dq_oe", dram_dq_oe, e.dqoe);
            chk("R10", "req_ready", req_ready, e.rdy);
            chk("R6", "rsp_valid", rsp_valid, e.rsp);
            if (e.chk_a) chk((e.ph == PH_RCD) ? "R2" : "R3", "dram_addr", dram_addr, e.a);
            if (e.chk_d) chk("R4", "dq_out", dram_dq_out, e.d);
            if (e.rsp)   chk("R6", "rsp_rdata", rsp_rdata, e.rd);
        end
    end

    // builds the expected timeline for one request accepted at the next edge
    task automatic gen(input int row, input int col, input bit wr, input bit [1:0] be, input logic [15:0] wd);
        int idx = cyc + 1, k, n, key = row * 1024 + col;
        logic [15:0] cur, exp_rd;
        exp_t e;
        cur = ref_mem.exists(key) ? ref_mem[key] : dflt(key);
        exp_rd = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
        if (model_open && row == model_row) begin
            k = idx - ras_fall;
        end else begin
            if (model_open) begin
                for (int i = 0; i < T_RP; i++) begin e = mk(PH_PRE); e.ras = 1; q.push_back(e); end
                idx += T_RP;
            end
            ras_fall = idx;
            for (int i = 0; i < T_RCD; i++) begin
                e = mk(PH_RCD); e.chk_a = 1; e.a = 12'(row); q.push_back(e);
            end
            k = T_RCD;
        end
        n = (!wr && (T_RAC - k > T_CAC)) ? T_RAC - k : T_CAC;
        for (int i = 0; i < n; i++) begin
            e = mk(PH_CAS);
            e.lcas = !be[0]; e.ucas = !be[1]; e.we = !wr; e.oe = wr; e.dqoe = wr;
            e.chk_a = 1; e.a = 12'(col); e.chk_d = wr; e.d = wd;
            q.push_back(e);
        end
        for (int i = 0; i < T_CP; i++) begin
            e = mk(PH_CPRE);
            if (i == 0 && !wr) begin e.rsp = 1; e.rd = exp_rd; end
            q.push_back(e);
        end
        if (wr) begin
            if (be[0]) cur[7:0]  = wd[7:0];
            if (be[1]) cur[15:8] = wd[15:8];
            ref_mem[key] = cur;
        end
        model_open = 1;
        model_row  = row;
    endtask

    task automatic issue(input int row, input int col, input bit wr, input bit [1:0] be, input logic [15:0] wd);
        while (!cur_idle) @(negedge clk);
        req_valid = 1; req_addr = {12'(row), 10'(col)}; req_write = wr; req_be = be; req_wdata = wd;
        gen(row, col, wr, be, wd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0; req_be = 0; req_wdata = 16'hDEAD; req_addr = 22'h3FFFFF;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);                 // R10: idle with valid low
        issue(5, 3, 1, 2'b11, 16'hC0DE);           // R2 closed-bank write
        issue(5, 3, 0, 2'b11, 16'h0);              // R5 page hit limited by row access
        issue(5, 4, 1, 2'b01, 16'h1111);           // R3 low byte only
        issue(5, 4, 1, 2'b10, 16'h2222);           // R3 high byte only
        issue(5, 4, 0, 2'b11, 16'h0);              // R6 merged word
        issue(5, 3, 0, 2'b01, 16'h0);              // R6 high lane zero
        issue(5, 3, 1, 2'b00, 16'hFFFF);           // R3 no lane enabled
        issue(5, 3, 0, 2'b10, 16'h0);              // R6 unchanged by empty write
        repeat (20) @(negedge clk);                // R7 row stays open
        issue(777, 1023, 0, 2'b11, 16'h0);         // R9 row change, unwritten data
        issue(777, 0, 1, 2'b11, 16'hABCD);         // R8 back-to-back hits
        issue(777, 0, 0, 2'b11, 16'h0);
        issue(0, 0, 0, 2'b11, 16'h0);              // R9 row zero
        issue(4095, 512, 1, 2'b11, 16'h5555);      // R9 top row
        issue(4095, 512, 0, 2'b11, 16'h0);
        while (!cur_idle) @(negedge clk);
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule